// File: doc/BRIEF.md
# Bit-Banged Management Interface PHY Responder

This block plays the PHY side of a serial management link. Software runs the link by hand through a 4-bit control word. Each time it writes that word, it sets or clears the management clock, the bit it drives, and its output enable. The responder watches these writes for a low-to-high step on the clock bit. On each such step it shifts in one bit. It finds frame alignment from a run of thirty-two ones. It then decodes the 16-bit command that follows.

A read command returns the contents of one entry of a 32 x 16-bit PHY register image. The value comes back on a return bit of the control word, most significant bit first. A write command stores the sixteen data bits into the addressed entry once the last of them arrives. The PHY address field of the command is not compared, so every address reaches the same image.

Top module: `mdio_phy_responder`

## Requirements
- R1: Control word layout is: bit 0 = host data, bit 1 = returned data, bit 2 = host output enable, bit 3 = clock. A host write stores bits 0, 2 and 3 as written. Bit 1 is never changed by a host write; only the block drives it.
- R2: A bit is sampled only on a host write that takes the clock bit from 0 to 1. The sampled bit is 1 only when both host data and output enable are 1 in that write. A write that keeps the clock at 1 samples nothing.
- R3: Thirty-two consecutive sampled ones align the frame. A command sent without this alignment run is not acted on.
- R4: The 16-bit command after alignment is laid out, high to low, as: start 15:14, opcode 13:12, PHY address 11:7, register address 6:2, turnaround 1:0. Start 01, opcode 10 with turnaround bit 0 equal to 0 is a read. On each of the next 16 clock rises, the read puts the addressed register on bit 1, MSB first.
- R5: Start 01, opcode 01 with turnaround 10 is a write. The 16 bits sampled after the command are stored in the addressed register on the 16th of those clock rises.
- R6: Any other command pattern returns the block to idle. Nothing is stored.
- R7: A synchronous active-high reset clears the control word and all registers, except two. Register 2 resets to 0x0022 and register 3 resets to 0x161A.
- R8: The PHY address field is ignored. Every address reaches the same register image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWrEn | input | 1 | Host writes the control word this cycle |
| hostWrData | input | 4 | Value the host writes to the control word |
| ctrlReg | output | 4 | Current control word as the host reads it back |

## Verification
Reads of the reset image at several addresses show whether the register image is correct and whether the bits come out MSB first. A write followed by a read-back at a different PHY address shows both the commit timing and that the address field is ignored.

A command with no alignment run, and commands with a bad start, opcode or turnaround, must leave their target register at zero. This separates decode rejection from acceptance. One frame repeats writes with the clock held high and the data bit flipped, and must still store the intended value, which isolates edge detection. During reads the host drives data high with output enable low, which shows that the enable gates the sampled bit.

// File: rtl/mdio_phy_pkg.sv
package mdio_phy_pkg;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = 2 * DATA_W;
  localparam int REG_CNT = 32;
  localparam int ADDR_W  = $clog2(REG_CNT);
  localparam int PHY_W   = 5;
  localparam int CNT_W   = $clog2(FRAME_W) + 2;

  // control word bit positions
  localparam int B_DO  = 0;
  localparam int B_DI  = 1;
  localparam int B_OE  = 2;
  localparam int B_CLK = 3;

  // command field positions inside the low DATA_W bits
  localparam int REG_LO = 2;
  localparam int PHY_LO = REG_LO + ADDR_W;
  localparam int OP_LO  = PHY_LO + PHY_W;
  localparam int ST_LO  = OP_LO + 2;

  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_t;

  typedef struct packed {
    logic latchAddr;
    logic loadRead;
    logic shiftOut;
    logic commit;
  } strobe_t;

  function automatic logic [DATA_W-1:0] resetValue(input int idx);
    case (idx)
      2:       return DATA_W'(16'h0022);
      3:       return DATA_W'(16'h161A);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/mdio_phy_datapath.sv
module mdio_phy_datapath
  import mdio_phy_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               hostWrEn,
  input  logic [3:0]         hostWrData,
  input  strobe_t            stb,
  output logic               risingEdge,
  output logic [FRAME_W-1:0] shiftNext,
  output logic [3:0]         ctrlReg
);
  logic doBit, oeBit, clkBit, diBit;
  logic [FRAME_W-1:0] shiftReg;
  logic [DATA_W-1:0]  dataOut;
  logic [ADDR_W-1:0]  regAddr;
  logic [DATA_W-1:0]  regFile [REG_CNT];
  logic               sampleBit;
  logic [ADDR_W-1:0]  hdrAddr;

  // clkBit doubles as the previous-clock flag
  assign risingEdge = hostWrEn & hostWrData[B_CLK] & ~clkBit;
  assign sampleBit  = hostWrData[B_DO] & hostWrData[B_OE];
  assign shiftNext  = {shiftReg[FRAME_W-2:0], sampleBit};
  assign hdrAddr    = shiftNext[REG_LO +: ADDR_W];
  assign ctrlReg    = {clkBit, oeBit, diBit, doBit};

  always_ff @(posedge clk) begin
    if (rst) begin
      doBit    <= 1'b0;
      oeBit    <= 1'b0;
      clkBit   <= 1'b0;
      diBit    <= 1'b0;
      shiftReg <= '0;
      dataOut  <= '0;
      regAddr  <= '0;
    end else begin
      if (hostWrEn) begin
        doBit  <= hostWrData[B_DO];
        oeBit  <= hostWrData[B_OE];
        clkBit <= hostWrData[B_CLK];
      end
      if (risingEdge) shiftReg <= shiftNext;
      if (stb.latchAddr) regAddr <= hdrAddr;
      if (stb.loadRead) dataOut <= regFile[hdrAddr];
      if (stb.shiftOut) begin
        diBit   <= dataOut[DATA_W-1];
        dataOut <= {dataOut[DATA_W-2:0], 1'b0};
      end
    end
  end

  for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regFile[i] <= resetValue(i);
      else if (stb.commit && regAddr == ADDR_W'(i)) regFile[i] <= shiftNext[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/mdio_phy_control.sv
module mdio_phy_control
  import mdio_phy_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               risingEdge,
  input  logic [FRAME_W-1:0] shiftNext,
  output strobe_t            stb,
  output phase_t             phase
);
  localparam logic signed [CNT_W-1:0] CNT_SYNC = CNT_W'(FRAME_W);
  localparam logic signed [CNT_W-1:0] CNT_DEC  = CNT_W'(DATA_W);
  localparam logic signed [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic signed [CNT_W-1:0] CNT_PARK = '1;

  logic signed [CNT_W-1:0] cnt, cntAfter, cntNext;
  phase_t phaseMid;
  logic [1:0] startF, opF, taF;
  logic isRead, isWrite;

  assign startF  = shiftNext[ST_LO +: 2];
  assign opF     = shiftNext[OP_LO +: 2];
  assign taF     = shiftNext[1:0];
  assign isWrite = (startF == 2'b01) && (opF == 2'b01) && (taF == 2'b10);
  assign isRead  = (startF == 2'b01) && (opF == 2'b10) && !taF[0];

  always_comb begin
    stb      = '0;
    cntAfter = cnt;
    phaseMid = phase;
    cntNext  = cnt;
    if (risingEdge) begin
      cntAfter = (&shiftNext) ? CNT_SYNC : cnt;
      if (cntAfter == CNT_DEC) begin
        phaseMid      = isWrite ? PH_WRITE : (isRead ? PH_READ : PH_IDLE);
        stb.latchAddr = isWrite || isRead;
        stb.loadRead  = isRead;
      end
      if ((cntAfter < CNT_DEC) && (phaseMid == PH_READ)) stb.shiftOut = 1'b1;
      if ((cntAfter == CNT_ZERO) && (phaseMid != PH_IDLE)) begin
        stb.commit = (phaseMid == PH_WRITE);
        phaseMid   = PH_IDLE;
      end
      // counter parks at -1 once a frame is over
      cntNext = (cntAfter == CNT_PARK) ? cntAfter : cntAfter - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= CNT_PARK;
      phase <= PH_IDLE;
    end else begin
      cnt   <= cntNext;
      phase <= phaseMid;
    end
  end
endmodule

// File: rtl/mdio_phy_responder.sv
module mdio_phy_responder
  import mdio_phy_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hostWrEn,
  input  logic [3:0] hostWrData,
  output logic [3:0] ctrlReg
);
  strobe_t            stb;
  phase_t             phase;
  logic               risingEdge;
  logic [FRAME_W-1:0] shiftNext;

  mdio_phy_control ctrl_i (
    .clk(clk), .rst(rst), .risingEdge(risingEdge), .shiftNext(shiftNext),
    .stb(stb), .phase(phase)
  );

  mdio_phy_datapath dp_i (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .stb(stb), .risingEdge(risingEdge), .shiftNext(shiftNext), .ctrlReg(ctrlReg)
  );
endmodule

// File: rtl/mdio_phy_checker.sv
module mdio_phy_checker
  import mdio_phy_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       hostWrEn,
  input logic [3:0] hostWrData,
  input logic [3:0] ctrlReg,
  input strobe_t    stb,
  input phase_t     phase
);
  p_host_bits_r1: assert property (@(posedge clk) disable iff (rst)
    hostWrEn |=> (ctrlReg[B_CLK] == $past(hostWrData[B_CLK])) &&
                 (ctrlReg[B_OE] == $past(hostWrData[B_OE])) &&
                 (ctrlReg[B_DO] == $past(hostWrData[B_DO])));

  p_di_owned_r1: assert property (@(posedge clk) disable iff (rst)
    !stb.shiftOut |=> ctrlReg[B_DI] == $past(ctrlReg[B_DI]));

  p_quiet_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !hostWrEn |=> $stable(ctrlReg));

  p_strobe_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (stb.loadRead || stb.shiftOut || stb.commit) |->
      (hostWrEn && hostWrData[B_CLK] && !ctrlReg[B_CLK]));

  p_excl_strobes_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.loadRead, stb.shiftOut, stb.commit}));

  p_shift_in_read_r4: assert property (@(posedge clk) disable iff (rst)
    stb.shiftOut |-> phase == PH_READ);

  p_commit_in_write_r5: assert property (@(posedge clk) disable iff (rst)
    stb.commit |-> phase == PH_WRITE);
endmodule

bind mdio_phy_responder mdio_phy_checker chk_i (
  .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
  .ctrlReg(ctrlReg), .stb(stb), .phase(phase)
);

// File: tb/mdio_phy_responder_tb.sv
module mdio_phy_responder_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic hostWrEn;
  logic [3:0] hostWrData;
  logic [3:0] ctrlReg;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mdio_phy_responder dut_i (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostWrData(hostWrData), .ctrlReg(ctrlReg)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [3:0] v);
    @(negedge clk);
    hostWrEn = 1'b1;
    hostWrData = v;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  // one clock period on the link; di is the returned bit after the rise
  task automatic linkBit(input logic b, input logic oe, input logic glitch, output logic di);
    hostWrite({1'b0, oe, 1'b0, b});
    hostWrite({1'b1, oe, 1'b0, b});
    di = ctrlReg[1];
    // clock stays high, data flips and bit 1 is poked: no sample (R2, R1)
    if (glitch) hostWrite({1'b1, oe, 1'b1, ~b});
  endtask

  task automatic preamble();
    logic d;
    for (int i = 0; i < 32; i++) linkBit(1'b1, 1'b1, 1'b0, d);
  endtask

  task automatic sendFrame(input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [1:0] ta, input logic [15:0] data,
                           input logic pre, input logic glitch);
    logic [31:0] f;
    logic d;
    f = {st, op, phy, rg, ta, data};
    if (pre) preamble();
    for (int i = 31; i >= 0; i--) linkBit(f[i], 1'b1, glitch, d);
  endtask

  // host drives data high with enable low after the address (R2)
  task automatic readReg(input logic [4:0] phy, input logic [4:0] rg, output logic [15:0] val);
    logic [13:0] h;
    logic d;
    h = {2'b01, 2'b10, phy, rg};
    val = '0;
    preamble();
    for (int i = 13; i >= 0; i--) linkBit(h[i], 1'b1, 1'b0, d);
    for (int i = 0; i < 2; i++) linkBit(1'b1, 1'b0, 1'b0, d);
    for (int i = 0; i < 16; i++) begin
      linkBit(1'b1, 1'b0, 1'b0, d);
      val = {val[14:0], d};
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_values();
    logic [15:0] v;
    chk("R7 control word after reset", {12'b0, ctrlReg}, 16'h0);
    readReg(5'd0, 5'd2, v);  chk("R7 R4 reg2 reset", v, 16'h0022);
    readReg(5'd0, 5'd3, v);  chk("R7 R4 reg3 reset", v, 16'h161A);
    readReg(5'd0, 5'd0, v);  chk("R7 reg0 reset", v, 16'h0000);
    readReg(5'd0, 5'd31, v); chk("R7 reg31 reset", v, 16'h0000);
  endtask

  task automatic t_ctrl_bits();
    logic [15:0] v;
    hostWrite(4'b0000);
    hostWrite(4'b0010);
    chk("R1 host cannot set bit1", {12'b0, ctrlReg}, 16'h0000);
    hostWrite(4'b0101);
    chk("R1 host bits stored", {12'b0, ctrlReg}, 16'h0005);
    sendFrame(2'b01, 2'b01, 5'd3, 5'd10, 2'b10, 16'h0001, 1'b1, 1'b0);
    readReg(5'd3, 5'd10, v);
    chk("R5 reg10 written", v, 16'h0001);
    hostWrite(4'b0000);
    chk("R1 host cannot clear bit1", {12'b0, ctrlReg}, 16'h0002);
  endtask

  task automatic t_write_read();
    logic [15:0] v;
    sendFrame(2'b01, 2'b01, 5'd1, 5'd5, 2'b10, 16'hA5C3, 1'b1, 1'b0);
    readReg(5'd17, 5'd5, v); chk("R5 R8 reg5 read at other phy", v, 16'hA5C3);
    readReg(5'd0, 5'd5, v);  chk("R8 reg5 read at phy0", v, 16'hA5C3);
  endtask

  task automatic t_no_preamble();
    logic [15:0] v;
    sendFrame(2'b01, 2'b01, 5'd0, 5'd6, 2'b10, 16'h1234, 1'b0, 1'b0);
    readReg(5'd0, 5'd6, v); chk("R3 write without alignment ignored", v, 16'h0000);
  endtask

  task automatic t_invalid();
    logic [15:0] v;
    sendFrame(2'b01, 2'b01, 5'd0, 5'd7, 2'b11, 16'hBEEF, 1'b1, 1'b0);
    sendFrame(2'b01, 2'b11, 5'd0, 5'd7, 2'b10, 16'hBEEF, 1'b1, 1'b0);
    sendFrame(2'b00, 2'b01, 5'd0, 5'd7, 2'b10, 16'hBEEF, 1'b1, 1'b0);
    readReg(5'd0, 5'd7, v); chk("R6 invalid commands store nothing", v, 16'h0000);
  endtask

  task automatic t_glitch();
    logic [15:0] v;
    sendFrame(2'b01, 2'b01, 5'd9, 5'd9, 2'b10, 16'h5A5A, 1'b1, 1'b1);
    readReg(5'd9, 5'd9, v); chk("R2 held clock samples nothing", v, 16'h5A5A);
  endtask

  task automatic t_reset_again();
    logic [15:0] v;
    doReset();
    chk("R7 control word cleared", {12'b0, ctrlReg}, 16'h0000);
    readReg(5'd0, 5'd5, v); chk("R7 reg5 cleared", v, 16'h0000);
    readReg(5'd0, 5'd2, v); chk("R7 reg2 restored", v, 16'h0022);
  endtask

  initial begin
    rst = 1'b1;
    hostWrEn = 1'b0;
    hostWrData = 4'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_values();
    t_ctrl_bits();
    t_write_read();
    t_no_preamble();
    t_invalid();
    t_glitch();
    t_reset_again();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule